// File: doc/BRIEF.md
# RTC Divider Chain with Periodic Interrupt

This block divides a 32.768 kHz clock-enable strobe with a 15-stage binary counter. A 4-bit rate code chooses one counter stage whose rising edge raises a periodic flag. The flag stays set until the status-read strobe clears it. The interrupt line is the flag masked by an enable bit. The top stage of the chain drives a one-cycle update tick once per second.

A 3-bit mode field controls the chain. It can stop the chain, run it normally, run it in a test mode where the upper stages step on every input strobe, or hold it cleared. All pins are plain control and status signals. The strobe input is sampled on the rising clock edge. There is no valid/ready stream and no back-pressure: every strobe seen with a running mode is counted in that same cycle. Flag, interrupt and update tick change at the clock edge that samples the strobe that causes the change.

Top module: `rtc_periodic_div`

## Requirements
- R1: The chain advances by one count for each cycle with `tick_en` high, only while `mode` is 010 (run) or 011 (test). With `mode` 000 or 001 the chain holds its value.
- R2: While `mode[2]` is 1 (values 100 to 111), the chain is forced to zero and stays there.
- R3: Rate code c from 3 to 15 selects divider output c-1. Output n is chain bit n-1 and has a period of 2^n strobes. Starting from a cleared chain, the first flag comes after 2^(c-2) strobes and each later one 2^(c-1) strobes after the previous.
- R4: Rate codes 0001 and 0010 behave exactly like codes 1000 and 1001. From a cleared chain they first set the flag after 64 and 128 strobes.
- R5: Rate code 0000 never sets the flag.
- R6: The flag sets on the rising edge of the selected stage. A cycle with `status_rd` high clears it. If a rise and a read fall in the same cycle, the flag ends up set.
- R7: `irq` is high exactly when the flag is set and `irq_en` is high.
- R8: `sec_tick` is a one-cycle pulse on each rise of the last chain stage. The first pulse comes 16384 strobes after leaving the cleared state, and later pulses come every 32768 strobes.
- R9: In test mode (011), chain stages 5 and up step on every strobe, independent of the lower stages. From a cleared chain, rate code 1111 sets the flag after 256 strobes instead of 8192.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | 32.768 kHz clock-enable strobe, one cycle per input tick |
| mode | input | 3 | Chain mode: 00x stop, 010 run, 011 test, 1xx clear |
| rate_sel | input | 4 | Periodic rate code |
| irq_en | input | 1 | Interrupt enable |
| status_rd | input | 1 | Status-read strobe; clears the periodic flag |
| per_flag | output | 1 | Periodic flag |
| irq | output | 1 | Periodic flag masked by `irq_en` |
| sec_tick | output | 1 | One-second update pulse |

## Verification
The rate function is tested with a fast code, with both members of each aliased code pair, with the slowest code, and with code zero. The first-rise count tells adjacent stages apart. The aliased pairs must agree with each other, which catches a wrong or monotonic mapping. Stop and clear modes are told apart by running a partly advanced chain through each mode and then counting strobes to the next flag. Test mode is told apart from run mode by the 256-strobe count on the slowest code. The update tick is counted across one full half-second and one full second.

// File: rtl/rtc_pdiv_pkg.sv
`timescale 1ns/1ps
package rtc_pdiv_pkg;

  typedef enum logic [1:0] {
    CH_STOP  = 2'd0,
    CH_RUN   = 2'd1,
    CH_TEST  = 2'd2,
    CH_CLEAR = 2'd3
  } chain_mode_e;

  typedef struct packed {
    logic       en;
    logic [3:0] bit_idx;
  } tap_sel_t;

  // Mode field decode: top bit forces clear, 00x stops, 01x runs.
  function automatic chain_mode_e decode_mode(input logic [2:0] m);
    if (m[2])       return CH_CLEAR;
    else if (!m[1]) return CH_STOP;
    else if (m[0])  return CH_TEST;
    else            return CH_RUN;
  endfunction

  // Rate code to chain bit. Divider output n is chain bit n-1.
  // Codes 1 and 2 alias outputs 7 and 8; codes 3..15 give outputs 2..14.
  function automatic tap_sel_t rate_to_tap(input logic [3:0] code);
    tap_sel_t t;
    t.en = 1'b1;
    unique case (code)
      4'd0:    begin t.en = 1'b0; t.bit_idx = 4'd0; end
      4'd1:    t.bit_idx = 4'd6;
      4'd2:    t.bit_idx = 4'd7;
      default: t.bit_idx = code - 4'd2;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/rtc_pdiv_mode_dec.sv
`timescale 1ns/1ps
module rtc_pdiv_mode_dec
  import rtc_pdiv_pkg::*;
(
  input  logic [2:0]  mode,
  output chain_mode_e cmode
);
  always_comb cmode = decode_mode(mode);
endmodule

// File: rtl/rtc_pdiv_chain.sv
`timescale 1ns/1ps
module rtc_pdiv_chain
  import rtc_pdiv_pkg::*;
#(
  parameter int CHAIN_W    = 15,
  parameter int TEST_SPLIT = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  chain_mode_e        cmode,
  output logic [CHAIN_W-1:0] cnt_q,
  output logic [CHAIN_W-1:0] rise
);
  localparam int LO_W = TEST_SPLIT;
  localparam int HI_W = CHAIN_W - TEST_SPLIT;

  logic               adv;
  logic               test_m;
  logic [LO_W-1:0]    lo_nxt;
  logic               lo_carry;
  logic               hi_step;
  logic [HI_W-1:0]    hi_nxt;
  logic [CHAIN_W-1:0] cnt_d;

  always_comb begin
    test_m   = (cmode == CH_TEST);
    adv      = tick_en && ((cmode == CH_RUN) || test_m);
    lo_nxt   = cnt_q[LO_W-1:0] + {{(LO_W-1){1'b0}}, 1'b1};
    lo_carry = &cnt_q[LO_W-1:0];
    hi_step  = test_m ? 1'b1 : lo_carry;
    hi_nxt   = cnt_q[CHAIN_W-1:LO_W] + {{(HI_W-1){1'b0}}, hi_step};
    if (cmode == CH_CLEAR) cnt_d = '0;
    else if (adv)          cnt_d = {hi_nxt, lo_nxt};
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < CHAIN_W; i++) begin : g_rise
    assign rise[i] = adv && !cnt_q[i] && cnt_d[i];
  end
endmodule

// File: rtl/rtc_pdiv_rate_sel.sv
`timescale 1ns/1ps
module rtc_pdiv_rate_sel
  import rtc_pdiv_pkg::*;
#(
  parameter int CHAIN_W = 15
) (
  input  logic [3:0]         rate_sel,
  input  logic [CHAIN_W-1:0] rise,
  output logic               tap_rise
);
  tap_sel_t sel;
  always_comb begin
    sel      = rate_to_tap(rate_sel);
    tap_rise = sel.en && rise[sel.bit_idx];
  end
endmodule

// File: rtl/rtc_pdiv_flag.sv
`timescale 1ns/1ps
module rtc_pdiv_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tap_rise,
  input  logic status_rd,
  input  logic irq_en,
  output logic per_flag,
  output logic irq
);
  logic flag_d;
  always_comb begin
    if (tap_rise)       flag_d = 1'b1;
    else if (status_rd) flag_d = 1'b0;
    else                flag_d = per_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) per_flag <= 1'b0;
    else        per_flag <= flag_d;
  end

  assign irq = per_flag && irq_en;
endmodule

// File: rtl/rtc_periodic_div.sv
`timescale 1ns/1ps
module rtc_periodic_div
  import rtc_pdiv_pkg::*;
#(
  parameter int CHAIN_W    = 15,
  parameter int TEST_SPLIT = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic [2:0] mode,
  input  logic [3:0] rate_sel,
  input  logic       irq_en,
  input  logic       status_rd,
  output logic       per_flag,
  output logic       irq,
  output logic       sec_tick
);
  chain_mode_e        cmode;
  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] rise;
  logic               tap_rise;

  rtc_pdiv_mode_dec u_mode (
    .mode  (mode),
    .cmode (cmode)
  );

  rtc_pdiv_chain #(.CHAIN_W(CHAIN_W), .TEST_SPLIT(TEST_SPLIT)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .cmode   (cmode),
    .cnt_q   (chain_q),
    .rise    (rise)
  );

  rtc_pdiv_rate_sel #(.CHAIN_W(CHAIN_W)) u_rate (
    .rate_sel (rate_sel),
    .rise     (rise),
    .tap_rise (tap_rise)
  );

  rtc_pdiv_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .tap_rise  (tap_rise),
    .status_rd (status_rd),
    .irq_en    (irq_en),
    .per_flag  (per_flag),
    .irq       (irq)
  );

  // Update tick: registered pulse on each rise of the last stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sec_tick <= 1'b0;
    else        sec_tick <= rise[CHAIN_W-1];
  end
endmodule

// File: rtl/rtc_pdiv_chk.sv
`timescale 1ns/1ps
module rtc_pdiv_chk #(
  parameter int CHAIN_W = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_en,
  input logic [2:0]         mode,
  input logic [3:0]         rate_sel,
  input logic               irq_en,
  input logic               status_rd,
  input logic               per_flag,
  input logic               irq,
  input logic               sec_tick,
  input logic [CHAIN_W-1:0] chain
);
  // R1: stop modes freeze the chain
  a_r1_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[2:1] == 2'b00) |=> $stable(chain));

  // R1: no strobe, no movement
  a_r1_no_tick_still: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !mode[2]) |=> $stable(chain));

  // R2: clear modes force zero
  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mode[2] |=> (chain == '0));

  // R5: code zero never raises the flag
  a_r5_no_rate_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 4'd0 && !per_flag) |=> !per_flag);

  // R6: a read without a strobe leaves the flag clear
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !tick_en) |=> !per_flag);

  // R6: the flag can only rise with a strobe
  a_r6_set_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !per_flag) |=> !per_flag);

  // R7: interrupt masked by enable
  a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (per_flag && irq_en) |-> irq);

  // R8: update tick lasts one cycle
  a_r8_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);
endmodule

bind rtc_periodic_div rtc_pdiv_chk #(.CHAIN_W(CHAIN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .mode      (mode),
  .rate_sel  (rate_sel),
  .irq_en    (irq_en),
  .status_rd (status_rd),
  .per_flag  (per_flag),
  .irq       (irq),
  .sec_tick  (sec_tick),
  .chain     (chain_q)
);

// File: tb/rtc_periodic_div_bench.sv
`timescale 1ns/1ps
module rtc_periodic_div_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [2:0] mode = 3'b100;
  logic [3:0] rate_sel = 4'd0;
  logic       irq_en = 1'b0;
  logic       status_rd = 1'b0;
  logic       per_flag, irq, sec_tick;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_periodic_div u_rtc_periodic_div (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode(mode),
    .rate_sel(rate_sel), .irq_en(irq_en), .status_rd(status_rd),
    .per_flag(per_flag), .irq(irq), .sec_tick(sec_tick)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  // Clear the chain, clear the flag, then enter the given mode.
  task automatic restart(input logic [3:0] code, input logic [2:0] m);
    rate_sel  = code;
    mode      = 3'b100;
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
    mode      = m;
    @(negedge clk);
  endtask

  task automatic first_rise(input string req, input logic [3:0] code,
                            input logic [2:0] m, input int n);
    restart(code, m);
    ticks(n - 1);
    chk({req, " no flag before first rise"}, per_flag, 1'b0);
    ticks(1);
    chk({req, " flag at first rise"}, per_flag, 1'b1);
  endtask

  task automatic t_reset_state;
    chk("R6 flag after reset", per_flag, 1'b0);
    chk("R7 irq after reset", irq, 1'b0);
    chk("R8 tick after reset", sec_tick, 1'b0);
  endtask

  task automatic t_fast_rate;
    first_rise("R3 code3", 4'd3, 3'b010, 2);
    status_rd = 1'b1; @(negedge clk); status_rd = 1'b0;
    chk("R6 read clears", per_flag, 1'b0);
    ticks(3);
    chk("R3 code3 period not early", per_flag, 1'b0);
    ticks(1);
    chk("R3 code3 period 4", per_flag, 1'b1);
  endtask

  task automatic t_irq;
    irq_en = 1'b0; @(negedge clk);
    chk("R7 irq masked", irq, 1'b0);
    irq_en = 1'b1; @(negedge clk);
    chk("R7 irq passes", irq, 1'b1);
    irq_en = 1'b0;
  endtask

  task automatic t_alias;
    first_rise("R4 code1", 4'd1, 3'b010, 64);
    first_rise("R4 code8", 4'd8, 3'b010, 64);
    first_rise("R4 code2", 4'd2, 3'b010, 128);
    first_rise("R4 code9", 4'd9, 3'b010, 128);
    first_rise("R3 code7", 4'd7, 3'b010, 32);
  endtask

  task automatic t_no_rate;
    restart(4'd0, 3'b010);
    ticks(300);
    chk("R5 code0 silent", per_flag, 1'b0);
  endtask

  task automatic t_stop;
    restart(4'd3, 3'b010);
    ticks(1);
    mode = 3'b001;
    ticks(5);
    chk("R1 stop holds", per_flag, 1'b0);
    mode = 3'b010;
    ticks(1);
    chk("R1 resumes from held count", per_flag, 1'b1);
  endtask

  task automatic t_clear;
    restart(4'd3, 3'b010);
    ticks(1);
    mode = 3'b110;
    ticks(3);
    mode = 3'b010;
    ticks(1);
    chk("R2 clear restarted chain", per_flag, 1'b0);
    ticks(1);
    chk("R2 first rise after clear", per_flag, 1'b1);
  endtask

  task automatic t_set_wins;
    restart(4'd3, 3'b010);
    ticks(1);
    status_rd = 1'b1;
    ticks(1);
    status_rd = 1'b0;
    chk("R6 set beats clear", per_flag, 1'b1);
  endtask

  task automatic t_test_mode;
    first_rise("R9 test code15", 4'd15, 3'b011, 256);
  endtask

  task automatic t_sec;
    int bad = 0;
    restart(4'd0, 3'b010);
    tick_en = 1'b1;
    for (int i = 1; i <= 49152; i++) begin
      @(negedge clk);
      if (sec_tick !== ((i == 16384) || (i == 49152))) bad++;
    end
    tick_en = 1'b0;
    checks++;
    if (bad != 0) begin
      failures++;
      $display("FAIL R8 sec_tick mismatches actual=%0d expected=0", bad);
    end
    @(negedge clk);
    chk("R8 pulse one cycle", sec_tick, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_fast_rate();
    t_irq();
    t_alias();
    t_no_rate();
    t_stop();
    t_clear();
    t_set_wins();
    t_test_mode();
    t_sec();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule